// File: doc/BRIEF.md
# Framebuffer Rectangle Transfer Address Generator

This block walks a rectangular region of a 16-bit-per-pixel video memory that holds 1024 pixels per line and 512 lines. It turns a 32-bit host word stream into pixel writes, or pixel reads into 32-bit host words. A start pulse captures the rectangle's top-left corner, its width and its height. The block then drives the memory address, the write strobe and the write data one pixel per cycle, and keeps its own column and row position.

Each host word carries two pixels, and the low half is always handled first. Moving to the next line adds a fixed stride of 1024 pixels to the line base. The linear address wraps modulo the memory size, so a rectangle that runs past the last pixel continues at address 0. When a write rectangle completes, a sticky frame-modified flag is raised and the image-ready status drops. An abort stops either direction at once. Decoding the commands that produce the start, abort and rectangle values is done elsewhere.

Top module: `fbx_rect_xfer`

## Requirements
- R1: After reset, `wr_busy`, `rd_busy`, `img_rdy`, `frame_dirty`, `mem_we`, `hw_ready` and `rd_ready` are all 0.
- R2: A `start_wr` pulse with a nonzero width and height sets `wr_busy` and `img_rdy`. A `start_rd` pulse with a nonzero width and height sets `rd_busy` and `img_rdy`. In both cases the first pixel address is `org_y*1024 + org_x`.
- R3: An accepted host word writes its bits 15:0 to the current address in the cycle of acceptance. It writes bits 31:16 to the following address in the next cycle, and `hw_ready` is 0 during that second cycle.
- R4: Within a line the address rises by 1 per pixel. After `rect_w` pixels the column returns to 0 and the address becomes the previous line start plus 1024.
- R5: A write ends once `rect_w*rect_h` pixels are written. At that point `wr_busy` and `img_rdy` fall and `frame_dirty` rises. If the total pixel count is odd, the upper half of the final word is not written.
- R6: Addresses are taken modulo 524288. Address 524287 is followed by 0, both along a line and when a line start is advanced.
- R7: A `rd_req` accepted while `rd_ready` is high fetches two consecutive pixels in consecutive cycles. Two cycles after acceptance, `rd_valid` is 1 for one cycle with `rd_data = {second pixel, first pixel}`.
- R8: A read always fetches the upper pixel, even past a line end or past the rectangle end. The read ends after the word in which the last rectangle pixel was fetched. Reads never change `frame_dirty`.
- R9: `abort` clears `wr_busy`, `rd_busy` and `img_rdy` at the next edge. It suppresses any memory write in its own cycle, and no later host word is written.
- R10: A start pulse with `rect_w` or `rect_h` equal to 0 is ignored.
- R11: `frame_dirty` stays set until a `dirty_ack` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Begin a host-to-memory rectangle |
| start_rd | input | 1 | Begin a memory-to-host rectangle |
| abort | input | 1 | Stop any transfer in progress |
| org_x | input | 10 | Rectangle left column |
| org_y | input | 9 | Rectangle top line |
| rect_w | input | 11 | Rectangle width in pixels (1..1024) |
| rect_h | input | 10 | Rectangle height in lines (1..512) |
| hw_valid | input | 1 | Host write word present |
| hw_data | input | 32 | Host write word, two pixels |
| hw_ready | output | 1 | Host write word accepted this cycle if valid |
| rd_req | input | 1 | Host requests one read word |
| rd_ready | output | 1 | A read request is accepted this cycle |
| rd_data | output | 32 | Packed read word |
| rd_valid | output | 1 | `rd_data` is valid |
| mem_addr | output | 19 | Linear pixel address |
| mem_we | output | 1 | Pixel write strobe |
| mem_wdata | output | 16 | Pixel write data |
| mem_rdata | input | 16 | Pixel read data, one cycle after address |
| wr_busy | output | 1 | Write rectangle active |
| rd_busy | output | 1 | Read rectangle active |
| img_rdy | output | 1 | Image-transfer ready status |
| frame_dirty | output | 1 | Sticky: a write rectangle completed |
| dirty_ack | input | 1 | Clears `frame_dirty` |

## Verification
Writes are tried with an even-sized rectangle, an odd pixel count and a rectangle at the bottom-right corner of memory. These separate the line-stride jump from plain incrementing, show that the dangling upper half is dropped, and exercise wrapping both along a line and at the line start. Reads cover a rectangle whose second word crosses a line and one whose last word fetches beyond the rectangle end. Together they tell correct upper-half fetching apart from fetching that stops at the line edge. Zero-size starts, an abort during the second half of a word and the acknowledge of the modified flag check the control paths.

// File: rtl/fbx_pkg.sv
package fbx_pkg;
   typedef enum logic [1:0] {
      M_IDLE = 2'd0,
      M_WR   = 2'd1,
      M_RD   = 2'd2
   } fbx_mode_t;

   typedef enum logic [1:0] {
      RP_IDLE = 2'd0,
      RP_HI   = 2'd1,
      RP_OUT  = 2'd2
   } fbx_rph_t;
endpackage

// File: rtl/fbx_rect_walker.sv
module fbx_rect_walker #(
   parameter int X_BITS = 10,
   parameter int Y_BITS = 9
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [X_BITS-1:0]        org_x,
   input  logic [Y_BITS-1:0]        org_y,
   input  logic [X_BITS:0]          width,
   input  logic [Y_BITS:0]          height,
   input  logic                     step,
   output logic [X_BITS+Y_BITS-1:0] addr,
   output logic                     last
);
   localparam int ADDR_BITS = X_BITS + Y_BITS;
   localparam logic [ADDR_BITS-1:0] STRIDE = ADDR_BITS'(1) << X_BITS;

   logic [X_BITS:0]          col, wid;
   logic [Y_BITS:0]          row, hgt;
   logic [ADDR_BITS-1:0]     line_base;
   logic [X_BITS:0]          col_nx;
   logic                     col_wrap;
   logic [ADDR_BITS-1:0]     line_nx;

   assign col_nx   = col + 1'b1;
   assign col_wrap = (col_nx == wid);
   assign line_nx  = line_base + STRIDE;
   assign last     = col_wrap && ((row + 1'b1) == hgt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col       <= '0;
         row       <= '0;
         wid       <= '0;
         hgt       <= '0;
         line_base <= '0;
         addr      <= '0;
      end else if (load) begin
         col       <= '0;
         row       <= '0;
         wid       <= width;
         hgt       <= height;
         line_base <= {org_y, org_x};
         addr      <= {org_y, org_x};
      end else if (step) begin
         if (col_wrap) begin
            col       <= '0;
            row       <= row + 1'b1;
            line_base <= line_nx;
            addr      <= line_nx;
         end else begin
            col  <= col_nx;
            addr <= addr + 1'b1;
         end
      end
   end

   assert_col_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !col_wrap) |=> (addr == ADDR_BITS'($past(addr) + 1'b1)));

   assert_line_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && col_wrap) |=>
         (addr == ADDR_BITS'($past(addr) - ADDR_BITS'($past(col)) + STRIDE)));
endmodule

// File: rtl/fbx_rd_pack.sv
module fbx_rd_pack #(
   parameter int PIX_BITS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cap_lo,
   input  logic                  out_en,
   input  logic [PIX_BITS-1:0]   pix_in,
   output logic [2*PIX_BITS-1:0] word_out,
   output logic                  word_vld
);
   logic [PIX_BITS-1:0] lo_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      lo_q <= '0;
      else if (cap_lo) lo_q <= pix_in;
   end

   assign word_out = {pix_in, lo_q};
   assign word_vld = out_en;
endmodule

// File: rtl/fbx_rect_xfer.sv
module fbx_rect_xfer
   import fbx_pkg::*;
#(
   parameter int X_BITS   = 10,
   parameter int Y_BITS   = 9,
   parameter int PIX_BITS = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_wr,
   input  logic                     start_rd,
   input  logic                     abort,
   input  logic [X_BITS-1:0]        org_x,
   input  logic [Y_BITS-1:0]        org_y,
   input  logic [X_BITS:0]          rect_w,
   input  logic [Y_BITS:0]          rect_h,
   input  logic                     hw_valid,
   input  logic [2*PIX_BITS-1:0]    hw_data,
   output logic                     hw_ready,
   input  logic                     rd_req,
   output logic                     rd_ready,
   output logic [2*PIX_BITS-1:0]    rd_data,
   output logic                     rd_valid,
   output logic [X_BITS+Y_BITS-1:0] mem_addr,
   output logic                     mem_we,
   output logic [PIX_BITS-1:0]      mem_wdata,
   input  logic [PIX_BITS-1:0]      mem_rdata,
   output logic                     wr_busy,
   output logic                     rd_busy,
   output logic                     img_rdy,
   output logic                     frame_dirty,
   input  logic                     dirty_ack
);
   localparam int ADDR_BITS = X_BITS + Y_BITS;

   generate
      if (X_BITS < 1 || Y_BITS < 1 || PIX_BITS < 1) begin : g_bad_cfg
         $error("fbx_rect_xfer: widths must be positive");
      end
   endgenerate

   fbx_mode_t           mode;
   fbx_rph_t            rd_ph;
   logic                hi_pend;
   logic [PIX_BITS-1:0] hi_q;
   logic                rd_end;
   logic                img_q, dirty_q;
   logic                start_ok, go_wr, go_rd, load;
   logic                rd_fetch, step, w_last, wr_done;

   assign start_ok = (rect_w != '0) && (rect_h != '0);
   assign go_wr    = !abort && start_wr && start_ok;
   assign go_rd    = !abort && !start_wr && start_rd && start_ok;
   assign load     = go_wr || go_rd;

   assign wr_busy  = (mode == M_WR);
   assign rd_busy  = (mode == M_RD);
   assign hw_ready = wr_busy && !hi_pend;
   assign rd_ready = rd_busy && (rd_ph == RP_IDLE);

   assign mem_we    = !abort && !load && wr_busy && ((hw_valid && hw_ready) || hi_pend);
   assign mem_wdata = hi_pend ? hi_q : hw_data[PIX_BITS-1:0];
   assign rd_fetch  = !abort && !load &&
                      ((rd_req && rd_ready) || (rd_busy && rd_ph == RP_HI));
   assign step      = mem_we || rd_fetch;
   assign wr_done   = mem_we && w_last;

   fbx_rect_walker #(.X_BITS(X_BITS), .Y_BITS(Y_BITS)) u_walk (
      .clk(clk), .rst_n(rst_n), .load(load),
      .org_x(org_x), .org_y(org_y), .width(rect_w), .height(rect_h),
      .step(step), .addr(mem_addr), .last(w_last)
   );

   fbx_rd_pack #(.PIX_BITS(PIX_BITS)) u_pack (
      .clk(clk), .rst_n(rst_n),
      .cap_lo(rd_busy && rd_ph == RP_HI),
      .out_en(rd_busy && rd_ph == RP_OUT),
      .pix_in(mem_rdata), .word_out(rd_data), .word_vld(rd_valid)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode    <= M_IDLE;
         rd_ph   <= RP_IDLE;
         hi_pend <= 1'b0;
         hi_q    <= '0;
         rd_end  <= 1'b0;
         img_q   <= 1'b0;
      end else if (abort) begin
         mode    <= M_IDLE;
         rd_ph   <= RP_IDLE;
         hi_pend <= 1'b0;
         rd_end  <= 1'b0;
         img_q   <= 1'b0;
      end else if (load) begin
         mode    <= go_wr ? M_WR : M_RD;
         rd_ph   <= RP_IDLE;
         hi_pend <= 1'b0;
         rd_end  <= 1'b0;
         img_q   <= 1'b1;
      end else begin
         case (mode)
            M_WR: if (mem_we) begin
               if (w_last) begin
                  mode    <= M_IDLE;
                  img_q   <= 1'b0;
                  hi_pend <= 1'b0;
               end else if (!hi_pend) begin
                  hi_pend <= 1'b1;
                  hi_q    <= hw_data[2*PIX_BITS-1:PIX_BITS];
               end else begin
                  hi_pend <= 1'b0;
               end
            end
            M_RD: case (rd_ph)
               RP_IDLE: if (rd_fetch) begin
                  rd_ph  <= RP_HI;
                  rd_end <= w_last;
               end
               RP_HI: begin
                  rd_ph  <= RP_OUT;
                  rd_end <= rd_end || w_last;
               end
               default: begin
                  rd_ph <= RP_IDLE;
                  if (rd_end) begin
                     mode  <= M_IDLE;
                     img_q <= 1'b0;
                  end
               end
            endcase
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         dirty_q <= 1'b0;
      else if (wr_done)   dirty_q <= 1'b1;
      else if (dirty_ack) dirty_q <= 1'b0;
   end

   assign img_rdy     = img_q;
   assign frame_dirty = dirty_q;

   assert_second_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && hw_ready && !w_last) |=> (hi_pend && !hw_ready));

   assert_dirty_on_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_dirty) |-> $fell(wr_busy));

   assert_rd_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(rd_busy) && !$past(rd_valid)));

   assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> (!wr_busy && !rd_busy && !img_rdy));
endmodule

// File: tb/tb_fbx_rect_xfer.sv
module tb_fbx_rect_xfer;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_wr = 0, start_rd = 0, abort = 0;
   logic [9:0]  org_x = '0;
   logic [8:0]  org_y = '0;
   logic [10:0] rect_w = '0;
   logic [9:0]  rect_h = '0;
   logic        hw_valid = 0;
   logic [31:0] hw_data = '0;
   logic        hw_ready;
   logic        rd_req = 0;
   logic        rd_ready;
   logic [31:0] rd_data;
   logic        rd_valid;
   logic [18:0] mem_addr;
   logic        mem_we;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata;
   logic        wr_busy, rd_busy, img_rdy, frame_dirty;
   logic        dirty_ack = 0;

   int n_tests = 0;
   int n_fail  = 0;

   logic [15:0] vram [int];

   always #(CLK_PERIOD/2) clk = ~clk;

   fbx_rect_xfer dut (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
      .abort(abort), .org_x(org_x), .org_y(org_y), .rect_w(rect_w),
      .rect_h(rect_h), .hw_valid(hw_valid), .hw_data(hw_data),
      .hw_ready(hw_ready), .rd_req(rd_req), .rd_ready(rd_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .wr_busy(wr_busy), .rd_busy(rd_busy), .img_rdy(img_rdy),
      .frame_dirty(frame_dirty), .dirty_ack(dirty_ack)
   );

   function automatic logic [15:0] bg(input int a);
      return 16'(a) ^ 16'h5A5A;
   endfunction

   function automatic logic [15:0] peek(input int a);
      return vram.exists(a) ? vram[a] : bg(a);
   endfunction

   always @(posedge clk) begin
      if (mem_we) vram[int'(mem_addr)] = mem_wdata;
      mem_rdata <= peek(int'(mem_addr));
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic chk_px(input string tag, input int a, input logic [15:0] exp);
      chk(tag, {15'd0, vram.exists(a) ? 1'b1 : 1'b0, peek(a)}, {16'h0001, exp});
   endtask

   task automatic begin_rect(input bit wr, input int x, input int y, input int w, input int h);
      @(negedge clk);
      org_x = 10'(x); org_y = 9'(y); rect_w = 11'(w); rect_h = 10'(h);
      start_wr = wr; start_rd = !wr;
      @(negedge clk);
      start_wr = 0; start_rd = 0;
   endtask

   task automatic push_word(input logic [31:0] d);
      while (!hw_ready) @(negedge clk);
      hw_valid = 1; hw_data = d;
      @(negedge clk);
      hw_valid = 0;
   endtask

   task automatic pull_word(output logic [31:0] d);
      while (!rd_ready) @(negedge clk);
      rd_req = 1;
      @(negedge clk);
      rd_req = 0;
      @(negedge clk);
      chk("R7 rd_valid two cycles after request", {31'd0, rd_valid}, 32'd1);
      d = rd_data;
   endtask

   task automatic t_reset;
      chk("R1 wr_busy", {31'd0, wr_busy}, 0);
      chk("R1 rd_busy", {31'd0, rd_busy}, 0);
      chk("R1 img_rdy", {31'd0, img_rdy}, 0);
      chk("R1 frame_dirty", {31'd0, frame_dirty}, 0);
      chk("R1 mem_we/ready", {29'd0, mem_we, hw_ready, rd_ready}, 0);
   endtask

   task automatic t_zero_dim;
      begin_rect(1, 5, 5, 0, 4);
      chk("R10 zero width ignored", {30'd0, wr_busy, img_rdy}, 0);
      begin_rect(0, 5, 5, 4, 0);
      chk("R10 zero height ignored", {30'd0, rd_busy, img_rdy}, 0);
   endtask

   task automatic t_write_rect;
      begin_rect(1, 10, 3, 4, 2);
      chk("R2 write start busy/img", {30'd0, wr_busy, img_rdy}, 32'd3);
      chk("R2 first address", {13'd0, mem_addr}, 3*1024 + 10);
      for (int k = 0; k < 4; k++) begin
         push_word({16'h1001 + 16'(2*k), 16'h1000 + 16'(2*k)});
         if (k == 0) chk("R3 hw_ready low during upper half", {31'd0, hw_ready}, 0);
      end
      @(negedge clk);
      chk("R5 write end busy/img", {30'd0, wr_busy, img_rdy}, 0);
      chk("R5 frame_dirty set", {31'd0, frame_dirty}, 1);
      for (int i = 0; i < 4; i++) begin
         chk_px("R3 line0 pixel", 3*1024 + 10 + i, 16'h1000 + 16'(i));
         chk_px("R4 line1 pixel", 4*1024 + 10 + i, 16'h1004 + 16'(i));
      end
      chk("R4 nothing past line end", {31'd0, vram.exists(3*1024 + 14) ? 1'b1 : 1'b0}, 0);
   endtask

   task automatic t_dirty_hold;
      repeat (5) @(negedge clk);
      chk("R11 dirty held", {31'd0, frame_dirty}, 1);
      dirty_ack = 1;
      @(negedge clk);
      dirty_ack = 0;
      chk("R11 dirty cleared by ack", {31'd0, frame_dirty}, 0);
   endtask

   task automatic t_write_odd;
      begin_rect(1, 100, 0, 3, 1);
      push_word(32'h3001_3000);
      push_word(32'h3003_3002);
      chk("R5 odd write ends on low half", {30'd0, wr_busy, frame_dirty}, 32'd1);
      @(negedge clk);
      chk_px("R5 odd px0", 100, 16'h3000);
      chk_px("R5 odd px1", 101, 16'h3001);
      chk_px("R5 odd px2", 102, 16'h3002);
      chk("R5 dropped upper half", {31'd0, vram.exists(103) ? 1'b1 : 1'b0}, 0);
      dirty_ack = 1;
      @(negedge clk);
      dirty_ack = 0;
   endtask

   task automatic t_write_wrap;
      int exp_a [8] = '{524286, 524287, 0, 1, 1022, 1023, 1024, 1025};
      begin_rect(1, 1022, 511, 4, 2);
      chk("R2 corner first address", {13'd0, mem_addr}, 524286);
      for (int k = 0; k < 4; k++)
         push_word({16'h2001 + 16'(2*k), 16'h2000 + 16'(2*k)});
      @(negedge clk);
      for (int i = 0; i < 8; i++)
         chk_px("R6 wrapped pixel", exp_a[i], 16'h2000 + 16'(i));
      dirty_ack = 1;
      @(negedge clk);
      dirty_ack = 0;
   endtask

   task automatic t_read_straddle;
      logic [31:0] w;
      begin_rect(0, 10, 3, 3, 2);
      chk("R2 read start busy/img", {30'd0, rd_busy, img_rdy}, 32'd3);
      chk("R2 read first address", {13'd0, mem_addr}, 3*1024 + 10);
      pull_word(w);
      chk("R7 word0", w, 32'h1001_1000);
      pull_word(w);
      chk("R8 word straddles line", w, 32'h1004_1002);
      pull_word(w);
      chk("R7 word2", w, 32'h1006_1005);
      @(negedge clk);
      chk("R8 read ends", {30'd0, rd_busy, img_rdy}, 0);
      chk("R8 read leaves dirty clear", {31'd0, frame_dirty}, 0);
   endtask

   task automatic t_read_tail;
      logic [31:0] w;
      begin_rect(0, 10, 3, 3, 1);
      pull_word(w);
      chk("R7 tail word0", w, 32'h1001_1000);
      pull_word(w);
      chk("R8 upper half beyond rectangle", w, 32'h1004_1002);
      @(negedge clk);
      chk("R8 tail read ends", {31'd0, rd_busy}, 0);
   endtask

   task automatic t_abort;
      begin_rect(1, 200, 100, 8, 8);
      push_word(32'h4001_4000);
      abort = 1;
      @(negedge clk);
      abort = 0;
      chk("R9 abort clears state", {28'd0, wr_busy, rd_busy, img_rdy, hw_ready}, 0);
      chk_px("R9 low half before abort", 100*1024 + 200, 16'h4000);
      hw_valid = 1; hw_data = 32'h5555_6666;
      repeat (3) @(negedge clk);
      hw_valid = 0;
      chk("R9 upper half suppressed", {31'd0, vram.exists(100*1024 + 201) ? 1'b1 : 1'b0}, 0);
      chk("R9 no write after abort", {30'd0, mem_we, frame_dirty}, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_zero_dim();
      t_write_rect();
      t_dirty_hold();
      t_write_odd();
      t_write_wrap();
      t_read_straddle();
      t_read_tail();
      t_abort();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule